// File: doc/BRIEF.md
# Owner-Tracked Lock Arbiter

This block holds a small set of hardware semaphores shared by a group of processor cores. Each lock carries a held flag and the identity of the core that holds it. Cores do not reach the block at the same time. A hub slot pointer steps through the cores one per clock. The core named by the pointer, if it has a request pending, gets a grant for that cycle. Its request then moves into a one-entry execute register and is evaluated on the next clock. The result comes back on a shared response bus that is tagged with the core number.

A request is one of four operations, chosen by a 2-bit code. Acquire is 0 and release is 1. Both name a lock through the low bits of the argument. Stop is 2 and restart is 3. Both name a target core through the low bits of the argument, and either one resets that core. A reset core loses every lock it holds in the cycle the reset takes effect. A core can also be reset from outside through a per-core kill input. Any request from a core that is being reset, and that is still on its way into or through the block, is thrown away. Resets are applied first in each cycle, before the lock operation of that cycle is evaluated. A lock freed by a reset can therefore be taken by another core in the same cycle.

Top module: `lock_arbiter`

## Requirements
- R1: While reset is asserted, and right after it, no response is valid, no grant is given, the hub slot reads 0 and every lock is free.
- R2: The hub slot advances by one each clock and wraps from NCORE-1 to 0. In a cycle, only the core equal to the hub slot can be granted, and only if its request is pending. Contending cores are therefore served in rotation order starting from the current slot.
- R3: Acquire (op 0) of a free lock, where the lock index is arg[3:0], returns carry 1 and records the requester as owner.
- R4: Acquire of a lock held by another core returns carry 0 and leaves the owner unchanged.
- R5: Acquire by the core that already owns the lock returns carry 1 and leaves ownership unchanged.
- R6: Release (op 1) by the owner frees the lock and returns carry 1. Release by any other core, or of a free lock, returns carry 0 and has no effect.
- R7: Stop (op 2) or restart (op 3) with target core arg[3:0] returns carry 1 to the issuer. It also frees every lock the target holds in the execute cycle of the command.
- R8: A pulse on core_kill[c] frees every lock core c holds in that same cycle.
- R9: Resets of a cycle are applied before that cycle's lock operation. An acquire executing in the cycle its lock's owner is reset succeeds.
- R10: A core being reset in a cycle gets no grant in that cycle. An executing request whose issuing core is killed in that cycle produces no response and no effect. Together these cover a core N stopping core N+1 while N+1 is presenting its own request on the next slot.
- R11: A granted request yields exactly one response. It is valid two clocks after the grant cycle and carries the issuer's core number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| core_req_valid | input | NCORE | Per-core request pending flag, held until granted |
| core_req_op | input | 2*NCORE | Per-core operation code, core c at bits [2c+1:2c] |
| core_req_arg | input | ARGW*NCORE | Per-core argument: lock index or target core |
| core_kill | input | NCORE | External per-core reset pulse |
| req_grant | output | NCORE | One-hot grant: request of that core is taken this cycle |
| hub_slot | output | IDW | Core currently owning the hub slot |
| rsp_valid | output | 1 | Response valid |
| rsp_core | output | IDW | Core the response belongs to |
| rsp_carry | output | 1 | Operation result flag |

## Verification
Some properties are checked on every clock by assertions. At most one grant is given at a time. A response always follows a grant by two cycles. A held lock changes owner only across a reset of its previous owner. A lock is freed only by a release from its owner or by a reset of its owner. After a reset takes effect, no lock remains with the reset core. Other behaviour is only visible through the bench's scenarios. This covers the carry values for owner, non-owner and free-lock cases, and rotation order under contention. It also covers the same-cycle reuse of a lock freed by a kill, and the discarded request of a core stopped by its neighbour one slot earlier. A reference model checks the bench outputs every cycle.

// File: rtl/lock_arbiter_pkg.sv
package lock_arbiter_pkg;

  typedef enum logic [1:0] {
    OP_ACQUIRE = 2'd0,
    OP_RELEASE = 2'd1,
    OP_STOP    = 2'd2,
    OP_INIT    = 2'd3
  } lk_op_e;

  function automatic logic op_is_core_cmd(input lk_op_e op);
    return (op == OP_STOP) || (op == OP_INIT);
  endfunction

endpackage

// File: rtl/hub_slot_rot.sv
module hub_slot_rot #(
  parameter int NCORE = 16,
  localparam int IDW = $clog2(NCORE)
) (
  input  logic           clk,
  input  logic           rst_n,
  output logic [IDW-1:0] slot
);

  logic [IDW-1:0] slot_q, slot_d;

  always_comb begin
    if (slot_q == IDW'(NCORE - 1)) slot_d = '0;
    else                           slot_d = slot_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  assign slot = slot_q;

endmodule

// File: rtl/req_capture.sv
module req_capture
  import lock_arbiter_pkg::*;
#(
  parameter int NCORE = 16,
  parameter int ARGW  = 4,
  localparam int IDW = $clog2(NCORE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDW-1:0]    slot,
  input  logic [NCORE-1:0]  req_valid,
  input  logic [2*NCORE-1:0] req_op,
  input  logic [ARGW*NCORE-1:0] req_arg,
  input  logic [NCORE-1:0]  kill_mask,
  output logic [NCORE-1:0]  grant,
  output logic              ex_valid,
  output logic [IDW-1:0]    ex_core,
  output lk_op_e            ex_op,
  output logic [ARGW-1:0]   ex_arg
);

  int unsigned sidx;
  logic        take;
  lk_op_e      cap_op;
  logic [ARGW-1:0] cap_arg;

  logic            v_q, v_d;
  logic [IDW-1:0]  c_q;
  lk_op_e          o_q;
  logic [ARGW-1:0] a_q;

  always_comb begin
    sidx    = 32'(slot);
    take    = req_valid[sidx] && !kill_mask[sidx];
    cap_op  = lk_op_e'(req_op[2*sidx +: 2]);
    cap_arg = req_arg[ARGW*sidx +: ARGW];
    grant   = '0;
    if (take) grant[sidx] = 1'b1;
    v_d     = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_q <= '0;
      o_q <= OP_ACQUIRE;
      a_q <= '0;
    end else if (take) begin
      c_q <= slot;
      o_q <= cap_op;
      a_q <= cap_arg;
    end
  end

  assign ex_valid = v_q;
  assign ex_core  = c_q;
  assign ex_op    = o_q;
  assign ex_arg   = a_q;

  assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_kill_blocks_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & kill_mask) == '0);

endmodule

// File: rtl/lock_table.sv
module lock_table
  import lock_arbiter_pkg::*;
#(
  parameter int NCORE = 16,
  parameter int NLOCK = 16,
  parameter int ARGW  = 4,
  localparam int IDW = $clog2(NCORE),
  localparam int LIW = $clog2(NLOCK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_valid,
  input  logic [IDW-1:0]   ex_core,
  input  lk_op_e           ex_op,
  input  logic [ARGW-1:0]  ex_arg,
  input  logic [NCORE-1:0] kill_ext,
  output logic [NCORE-1:0] kill_mask,
  output logic             rsp_valid,
  output logic [IDW-1:0]   rsp_core,
  output logic             rsp_carry
);

  logic [NLOCK-1:0] vld_q, vld_d, post_kill;
  logic [IDW-1:0]   own_q [NLOCK];
  logic [IDW-1:0]   own_d [NLOCK];
  logic [NLOCK-1:0] own_en;
  logic             ex_live, carry_d;
  logic [LIW-1:0]   lk;
  logic             rv_q;
  logic [IDW-1:0]   rc_q;
  logic             ry_q;

  // reset sources of this cycle, applied ahead of the lock operation
  always_comb begin
    kill_mask = kill_ext;
    if (ex_valid && op_is_core_cmd(ex_op) && !kill_ext[ex_core])
      kill_mask[ex_arg[IDW-1:0]] = 1'b1;
  end

  always_comb begin
    ex_live = ex_valid && !kill_ext[ex_core];
    lk      = ex_arg[LIW-1:0];
    for (int i = 0; i < NLOCK; i++) begin
      post_kill[i] = vld_q[i] && !kill_mask[own_q[i]];
      own_d[i]     = own_q[i];
    end
    vld_d   = post_kill;
    own_en  = '0;
    carry_d = 1'b0;
    if (ex_live) begin
      unique case (ex_op)
        OP_ACQUIRE: begin
          if (!post_kill[lk]) begin
            vld_d[lk]  = 1'b1;
            own_d[lk]  = ex_core;
            own_en[lk] = 1'b1;
            carry_d    = 1'b1;
          end else begin
            carry_d = (own_q[lk] == ex_core);
          end
        end
        OP_RELEASE: begin
          if (post_kill[lk] && (own_q[lk] == ex_core)) begin
            vld_d[lk] = 1'b0;
            carry_d   = 1'b1;
          end
        end
        default: carry_d = 1'b1;
      endcase
    end
  end

  for (genvar g = 0; g < NLOCK; g++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[g] <= 1'b0;
      else        vld_q[g] <= vld_d[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         own_q[g] <= '0;
      else if (own_en[g]) own_q[g] <= own_d[g];
    end

    assert_owner_moves_only_on_kill_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[g] && $past(vld_q[g]) && (own_q[g] != $past(own_q[g])))
        |-> $past(kill_mask[own_q[g]]));

    assert_free_only_by_owner_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vld_q[g]) |-> $past(kill_mask[own_q[g]] ||
        (ex_valid && !kill_ext[ex_core] && ex_op == OP_RELEASE &&
         ex_arg[LIW-1:0] == LIW'(g) && ex_core == own_q[g])));

    assert_reset_frees_locks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[g] && kill_mask[own_q[g]]) |=> !(vld_q[g] && own_q[g] == $past(own_q[g])));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= ex_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_q <= '0;
      ry_q <= 1'b0;
    end else if (ex_live) begin
      rc_q <= ex_core;
      ry_q <= carry_d;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_core  = rc_q;
  assign rsp_carry = ry_q;

endmodule

// File: rtl/lock_arbiter.sv
module lock_arbiter
  import lock_arbiter_pkg::*;
#(
  parameter int NCORE = 16,
  parameter int NLOCK = 16,
  localparam int IDW  = $clog2(NCORE),
  localparam int LIW  = $clog2(NLOCK),
  localparam int ARGW = (IDW > LIW) ? IDW : LIW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCORE-1:0]      core_req_valid,
  input  logic [2*NCORE-1:0]    core_req_op,
  input  logic [ARGW*NCORE-1:0] core_req_arg,
  input  logic [NCORE-1:0]      core_kill,
  output logic [NCORE-1:0]      req_grant,
  output logic [IDW-1:0]        hub_slot,
  output logic                  rsp_valid,
  output logic [IDW-1:0]        rsp_core,
  output logic                  rsp_carry
);

  logic [NCORE-1:0] kill_mask;
  logic             ex_valid;
  logic [IDW-1:0]   ex_core;
  lk_op_e           ex_op;
  logic [ARGW-1:0]  ex_arg;

  hub_slot_rot #(.NCORE(NCORE)) i_slot (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (hub_slot)
  );

  req_capture #(.NCORE(NCORE), .ARGW(ARGW)) i_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (hub_slot),
    .req_valid (core_req_valid),
    .req_op    (core_req_op),
    .req_arg   (core_req_arg),
    .kill_mask (kill_mask),
    .grant     (req_grant),
    .ex_valid  (ex_valid),
    .ex_core   (ex_core),
    .ex_op     (ex_op),
    .ex_arg    (ex_arg)
  );

  lock_table #(.NCORE(NCORE), .NLOCK(NLOCK), .ARGW(ARGW)) i_tab (
    .clk       (clk),
    .rst_n     (rst_n),
    .ex_valid  (ex_valid),
    .ex_core   (ex_core),
    .ex_op     (ex_op),
    .ex_arg    (ex_arg),
    .kill_ext  (core_kill),
    .kill_mask (kill_mask),
    .rsp_valid (rsp_valid),
    .rsp_core  (rsp_core),
    .rsp_carry (rsp_carry)
  );

  assert_rsp_follows_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(|req_grant, 2));

  assert_rsp_core_matches_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_core == $past(hub_slot, 2));

endmodule

// File: tb/test_lock_arbiter.sv
module test_lock_arbiter;
  localparam int NC = 16;
  localparam int NL = 16;
  localparam int IW = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_n;
  logic [NC-1:0]   req_valid;
  logic [2*NC-1:0] req_op;
  logic [AW*NC-1:0] req_arg;
  logic [NC-1:0]   core_kill;
  logic [NC-1:0]   req_grant;
  logic [IW-1:0]   hub_slot;
  logic            rsp_valid;
  logic [IW-1:0]   rsp_core;
  logic            rsp_carry;

  lock_arbiter #(.NCORE(NC), .NLOCK(NL)) i_lock_arbiter (
    .clk(clk), .rst_n(rst_n), .core_req_valid(req_valid), .core_req_op(req_op),
    .core_req_arg(req_arg), .core_kill(core_kill), .req_grant(req_grant),
    .hub_slot(hub_slot), .rsp_valid(rsp_valid), .rsp_core(rsp_core), .rsp_carry(rsp_carry)
  );

  int tests = 0, fails = 0;

  // reference model state
  bit m_vld[NL];
  int m_own[NL];
  int m_slot;
  bit s_v; int s_c, s_o, s_a;
  bit r_v; int r_c; bit r_y;

  // scenario bookkeeping
  bit got[NC]; bit got_y[NC]; bit seen_grant[NC];
  logic [NC-1:0] pend_set, pend_clr, clr_next, kill_next;
  int pend_op[NC], pend_arg[NC];
  int arm_watch = -1, arm_victim = -1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    int kill_m [NC];
    bit mg [NC];
    bit pv [NL];
    bit live; logic [NC-1:0] gvec; int lk;
    // registered outputs versus model
    check(rsp_valid === r_v, "R11", "rsp_valid", rsp_valid, r_v);
    if (r_v) begin
      check(rsp_core == r_c, "R11", "rsp_core", rsp_core, r_c);
      check(rsp_carry == r_y, "R11", "rsp_carry", rsp_carry, r_y);
    end
    check(hub_slot == m_slot, "R2", "hub_slot", hub_slot, m_slot);
    if (rsp_valid) begin got[rsp_core] = 1; got_y[rsp_core] = rsp_carry; end
    // drive inputs for this cycle
    for (int c = 0; c < NC; c++) begin
      if (clr_next[c] || pend_clr[c]) req_valid[c] = 1'b0;
      if (pend_set[c]) begin
        req_valid[c] = 1'b1;
        req_op[2*c +: 2] = 2'(pend_op[c]);
        req_arg[AW*c +: AW] = 4'(pend_arg[c]);
      end
    end
    pend_set = '0; pend_clr = '0;
    core_kill = kill_next; kill_next = '0;
    #1;
    // model: resets first
    for (int c = 0; c < NC; c++) kill_m[c] = core_kill[c];
    if (s_v && s_o >= 2 && !core_kill[s_c]) kill_m[s_a] = 1;
    gvec = '0;
    for (int c = 0; c < NC; c++) begin
      mg[c] = (c == m_slot) && req_valid[c] && (kill_m[c] == 0);
      gvec[c] = mg[c];
    end
    check(req_grant == gvec, "R2", "req_grant", int'(req_grant), int'(gvec));
    for (int c = 0; c < NC; c++) if (mg[c]) seen_grant[c] = 1;
    if (arm_watch >= 0 && mg[arm_watch]) begin kill_next[arm_victim] = 1'b1; arm_watch = -1; end
    clr_next = gvec;
    for (int i = 0; i < NL; i++) pv[i] = m_vld[i] && (kill_m[m_own[i]] == 0);
    live = s_v && !core_kill[s_c];
    r_v = live; lk = s_a;
    if (live) begin
      r_c = s_c;
      r_y = 0;
      if (s_o == 0) begin
        if (!pv[lk]) begin pv[lk] = 1; m_own[lk] = s_c; r_y = 1; end
        else r_y = (m_own[lk] == s_c);
      end else if (s_o == 1) begin
        if (pv[lk] && m_own[lk] == s_c) begin pv[lk] = 0; r_y = 1; end
      end else r_y = 1;
    end
    for (int i = 0; i < NL; i++) m_vld[i] = pv[i];
    s_v = 0;
    for (int c = 0; c < NC; c++) if (mg[c]) begin
      s_v = 1; s_c = c; s_o = int'(req_op[2*c +: 2]); s_a = int'(req_arg[AW*c +: AW]);
    end
    m_slot = (m_slot + 1) % NC;
    @(negedge clk);
  endtask

  task automatic set_req(input int c, input int op, input int arg);
    got[c] = 0; seen_grant[c] = 0;
    pend_set[c] = 1'b1; pend_op[c] = op; pend_arg[c] = arg;
  endtask

  task automatic run_until(input int c);
    for (int n = 0; n < 64 && !got[c]; n++) step();
  endtask

  task automatic issue(input int c, input int op, input int arg, input int exp,
                       input string tag);
    set_req(c, op, arg);
    run_until(c);
    check(got[c] == 1, tag, "response arrived", got[c], 1);
    check(got_y[c] == exp[0], tag, "carry", got_y[c], exp);
  endtask

  task automatic align_slot0();
    for (int n = 0; n < NC && m_slot != 0; n++) step();
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int ones;
    rst_n = 1'b0; req_valid = '0; req_op = '0; req_arg = '0; core_kill = '0;
    pend_set = '0; pend_clr = '0; clr_next = '0; kill_next = '0;
    for (int i = 0; i < NL; i++) begin m_vld[i] = 0; m_own[i] = 0; end
    m_slot = 0; s_v = 0; r_v = 0; r_c = 0; r_y = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    check(hub_slot == '0, "R1", "hub_slot in reset", hub_slot, 0);
    check(req_grant == '0, "R1", "grant in reset", int'(req_grant), 0);
    rst_n = 1'b1;
    repeat (3) step();
    issue(0, 0, 0, 1, "R1 lock0 free after reset");
    issue(0, 1, 0, 1, "R6 owner release");
    // R3 / R5 / R4
    issue(3, 0, 5, 1, "R3 acquire free");
    issue(3, 0, 5, 1, "R5 reacquire by owner");
    issue(6, 0, 5, 0, "R4 acquire held by other");
    // R6 non-owner release has no effect
    issue(6, 1, 5, 0, "R6 release by non-owner");
    issue(6, 0, 5, 0, "R6 lock still held");
    issue(3, 1, 5, 1, "R6 release by owner");
    issue(3, 1, 5, 0, "R6 release of free lock");
    issue(6, 0, 5, 1, "R6 acquire after release");
    // R7 stop and restart free owned locks
    issue(6, 0, 1, 1, "R7 second lock");
    issue(0, 2, 6, 1, "R7 stop carry");
    issue(9, 0, 1, 1, "R7 lock1 freed by stop");
    issue(9, 0, 5, 1, "R7 lock5 freed by stop");
    issue(0, 3, 9, 1, "R7 restart carry");
    issue(2, 0, 1, 1, "R7 lock1 freed by restart");
    // R8 external kill
    kill_next[2] = 1'b1;
    step();
    issue(4, 0, 1, 1, "R8 lock1 freed by kill");
    // R9 kill of owner in same cycle as acquire
    arm_watch = 7; arm_victim = 4;
    issue(7, 0, 1, 1, "R9 acquire while owner killed");
    issue(4, 0, 1, 0, "R9 lock1 now owned by core 7");
    // R10: core 11 stops core 12, whose request sits on the next slot
    align_slot0();
    set_req(12, 0, 13);
    set_req(11, 2, 12);
    run_until(11);
    check(got_y[11] == 1, "R10", "stop carry", got_y[11], 1);
    pend_clr[12] = 1'b1;
    repeat (20) step();
    check(seen_grant[12] == 0, "R10", "stopped core granted", seen_grant[12], 0);
    check(got[12] == 0, "R10", "stopped core response", got[12], 0);
    issue(5, 0, 13, 1, "R10 dropped acquire left lock free");
    // R10: executing request killed
    arm_watch = 8; arm_victim = 8;
    set_req(8, 0, 10);
    repeat (24) step();
    check(seen_grant[8] == 1, "R10", "killed core was granted", seen_grant[8], 1);
    check(got[8] == 0, "R10", "killed request response", got[8], 0);
    issue(9, 0, 10, 1, "R10 killed acquire had no effect");
    // R2 contention: rotation from slot 0 favours the lowest core above it
    align_slot0();
    set_req(10, 0, 12); set_req(11, 0, 12); set_req(12, 0, 12);
    run_until(10); run_until(11); run_until(12);
    ones = got_y[10] + got_y[11] + got_y[12];
    check(ones == 1, "R2", "single winner", ones, 1);
    check(got_y[10] == 1, "R2", "rotation winner core10", got_y[10], 1);
    repeat (4) step();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule